// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

A bank of 32 general-purpose pins, organised as four 8-bit ports, behind a small word-wide register bus with per-byte lane enables. Software sets each pin's direction and output level, and marks pins that a peripheral owns. It also reads back pin levels and arms each pin to raise an interrupt on a falling edge, a rising edge or both. Pin inputs are synchronised through two flops before edge detection. Captured edges sit in a pending register that software clears by writing ones.

Pending bits are routed to one interrupt line per CPU through a per-CPU enable mask held in a second register window. When that window is left out at build time, a single interrupt line carries the OR of all pending bits. A build parameter swaps the byte lanes that carry each port, so that the same block can serve either port layout.

The bus carries a word address `bus_waddr`, and the byte offset is four times that value. Bit 3 selects the per-CPU window. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from the addressed word.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every main-window word (pin-select, direction, data output, pending, both edge-mask words) reads zero, every per-CPU enable word reads 0xFFFFFFFF, and all interrupt outputs are low.
- R2: Word 2 (direction, 1 = output) drives `pin_oe`. Word 3 (data) drives `pin_out`. Word 0 (pin-select, 1 = peripheral) drives `pin_alt`.
- R3: Reading word 3 returns, per pin, the driven data bit when the direction bit is 1. Otherwise it returns the pin level as sampled two clock edges earlier.
- R4: A write changes only the bytes whose `bus_be` bit is set. A write with all enables clear changes nothing.
- R5: Each pin has a 2-bit edge field at bit 2*pin of its port's 16-bit mask half. 00 means off, 01 means falling edge, 10 means rising edge and 11 means either edge. A qualifying edge sets that pin's bit in the pending word (word 4).
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R7: An edge that would set a pending bit on the same clock edge as a write-one-to-clear of that bit leaves the bit set.
- R8: In normal order, port p is on byte lane p of words 0, 2, 3 and 4 and of each per-CPU word. Word 5 holds port 0 in bits 15:0 and port 1 in bits 31:16. Word 6 holds port 2 in bits 15:0 and port 3 in bits 31:16.
- R9: In reversed order, port p is on byte lane 3-p. Word 5 holds port 1 in bits 15:0 and port 0 in bits 31:16. Word 6 holds port 3 in bits 15:0 and port 2 in bits 31:16.
- R10: The per-CPU enable word for CPU c is at word 8+c. Output `irq[c]` is high exactly when some pending bit is set whose enable bit for CPU c is set.
- R11: Words 1 and 7, and per-CPU words beyond the CPU count, read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_waddr | input | 4 | Word address; bit 3 selects the per-CPU window |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Driven pin levels |
| pin_oe | output | 32 | Output enables |
| pin_alt | output | 32 | Peripheral ownership per pin |
| irq | output | NUM_CPUS | Interrupt line per CPU |

## Verification
A pin edge can reach the pending register on the same clock edge as a software write that clears that pending bit. The bench provokes this by changing a pin and then issuing the clearing write exactly two clock edges later, when the synchronised edge is being recorded. After that write it expects the bit still set. A behavioural model also covers this collision as it tracks every cycle. Collisions between lane-enabled writes and reads of the two port orderings are judged against the same model and against fixed expected words.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int LANE_W = 8;
    localparam int PORTS  = 4;
    localparam int PINS   = PORTS * LANE_W;

    typedef enum logic [2:0] {
        W_ALT  = 3'd0,
        W_DIR  = 3'd2,
        W_DOUT = 3'd3,
        W_PEND = 3'd4,
        W_EMLO = 3'd5,
        W_EMHI = 3'd6
    } word_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    // byte lane that carries port p in the 8-bit-per-port words
    function automatic int port_lane(input int p, input bit rev);
        return rev ? (PORTS - 1 - p) : p;
    endfunction

    // 16-bit slot (0..3) that carries port p in the edge-mask words
    function automatic int mask_slot(input int p, input bit rev);
        return rev ? (p ^ 1) : p;
    endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = pin_in;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) sy_q <= '0;
        else     sy_q <= sy_d;
    end

    assign level = sy_q.s2;
    assign rise  = sy_q.s2 & ~sy_q.prev;
    assign fall  = ~sy_q.s2 & sy_q.prev;
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   rise,
    input  logic [N-1:0]   fall,
    input  logic [2*N-1:0] edge_mask,
    input  logic [N-1:0]   clr,
    output logic [N-1:0]   pending
);
    import gpio_bank_pkg::*;

    logic [N-1:0] hit;
    logic [N-1:0] pend_d, pend_q;

    for (genvar i = 0; i < N; i++) begin : g_pin
        edge_sel_e sel;
        assign sel    = edge_sel_e'(edge_mask[2*i +: 2]);
        assign hit[i] = ((sel == EDGE_RISE || sel == EDGE_ANY) && rise[i])
                     || ((sel == EDGE_FALL || sel == EDGE_ANY) && fall[i]);
    end

    always_comb begin
        pend_d = (pend_q & ~clr) | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign pending = pend_q;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((pending & $past(hit)) == $past(hit)));

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~hit) != '0) |=> ((pending & $past(clr & ~hit)) == '0));

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~$past(pending) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
    parameter int N           = 32,
    parameter int NUM_CPUS    = 2,
    parameter bit HAS_CPU_WIN = 1'b1,
    localparam int IRQ_W      = HAS_CPU_WIN ? NUM_CPUS : 1
) (
    input  logic [N-1:0]               pending,
    input  logic [NUM_CPUS-1:0][N-1:0] cpu_en,
    output logic [IRQ_W-1:0]           irq
);
    if (HAS_CPU_WIN) begin : g_percpu
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
            assign irq[c] = |(pending & cpu_en[c]);
        end
    end else begin : g_single
        assign irq[0] = |pending;
    end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_CPUS    = 2,
    parameter bit HAS_CPU_WIN = 1'b1,
    parameter bit REVERSED    = 1'b0,
    localparam int N          = PINS,
    localparam int IRQ_W      = HAS_CPU_WIN ? NUM_CPUS : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       bus_waddr,
    input  logic             bus_wr,
    input  logic [3:0]       bus_be,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [N-1:0]     pin_in,
    output logic [N-1:0]     pin_out,
    output logic [N-1:0]     pin_oe,
    output logic [N-1:0]     pin_alt,
    output logic [IRQ_W-1:0] irq
);
    typedef struct packed {
        logic [N-1:0]               alt;
        logic [N-1:0]               dir;
        logic [N-1:0]               dout;
        logic [2*N-1:0]             emask;
        logic [NUM_CPUS-1:0][N-1:0] cpu_en;
    } regs_t;

    regs_t        st_d, st_q;
    logic [N-1:0] clr;
    logic [N-1:0] level, rise, fall, pending;
    logic [N-1:0] rd_view;
    logic [2:0]   word;
    logic         cpu_win;

    assign word    = bus_waddr[2:0];
    assign cpu_win = bus_waddr[3];

    gpio_pin_sync #(.N(N)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .level(level), .rise(rise), .fall(fall)
    );

    gpio_edge_status #(.N(N)) u_status (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall),
        .edge_mask(st_q.emask), .clr(clr), .pending(pending)
    );

    gpio_irq_route #(.N(N), .NUM_CPUS(NUM_CPUS), .HAS_CPU_WIN(HAS_CPU_WIN)) u_route (
        .pending(pending), .cpu_en(st_q.cpu_en), .irq(irq)
    );

    // write side: next register state and clear strobes
    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (bus_wr && !cpu_win) begin
            for (int p = 0; p < PORTS; p++) begin
                if (bus_be[port_lane(p, REVERSED)]) begin
                    unique case (word)
                        W_ALT:  st_d.alt[LANE_W*p +: LANE_W]  = bus_wdata[LANE_W*port_lane(p, REVERSED) +: LANE_W];
                        W_DIR:  st_d.dir[LANE_W*p +: LANE_W]  = bus_wdata[LANE_W*port_lane(p, REVERSED) +: LANE_W];
                        W_DOUT: st_d.dout[LANE_W*p +: LANE_W] = bus_wdata[LANE_W*port_lane(p, REVERSED) +: LANE_W];
                        W_PEND: clr[LANE_W*p +: LANE_W]       = bus_wdata[LANE_W*port_lane(p, REVERSED) +: LANE_W];
                        default: ;
                    endcase
                end
                if (word == 3'(int'(W_EMLO) + mask_slot(p, REVERSED) / 2)) begin
                    for (int k = 0; k < 2; k++) begin
                        if (bus_be[2*(mask_slot(p, REVERSED) % 2) + k]) begin
                            st_d.emask[2*LANE_W*p + LANE_W*k +: LANE_W] =
                                bus_wdata[LANE_W*(2*(mask_slot(p, REVERSED) % 2) + k) +: LANE_W];
                        end
                    end
                end
            end
        end else if (bus_wr && cpu_win && HAS_CPU_WIN) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                if (word == 3'(c)) begin
                    for (int p = 0; p < PORTS; p++) begin
                        if (bus_be[port_lane(p, REVERSED)]) begin
                            st_d.cpu_en[c][LANE_W*p +: LANE_W] =
                                bus_wdata[LANE_W*port_lane(p, REVERSED) +: LANE_W];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '0;
            st_q.cpu_en <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_view = (st_q.dir & st_q.dout) | (~st_q.dir & level);

    // read side: combinational from the addressed word
    always_comb begin
        bus_rdata = '0;
        if (!cpu_win) begin
            for (int p = 0; p < PORTS; p++) begin
                unique case (word)
                    W_ALT:  bus_rdata[LANE_W*port_lane(p, REVERSED) +: LANE_W] = st_q.alt[LANE_W*p +: LANE_W];
                    W_DIR:  bus_rdata[LANE_W*port_lane(p, REVERSED) +: LANE_W] = st_q.dir[LANE_W*p +: LANE_W];
                    W_DOUT: bus_rdata[LANE_W*port_lane(p, REVERSED) +: LANE_W] = rd_view[LANE_W*p +: LANE_W];
                    W_PEND: bus_rdata[LANE_W*port_lane(p, REVERSED) +: LANE_W] = pending[LANE_W*p +: LANE_W];
                    default: ;
                endcase
                if (word == 3'(int'(W_EMLO) + mask_slot(p, REVERSED) / 2)) begin
                    bus_rdata[2*LANE_W*(mask_slot(p, REVERSED) % 2) +: 2*LANE_W] =
                        st_q.emask[2*LANE_W*p +: 2*LANE_W];
                end
            end
        end else if (HAS_CPU_WIN) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                if (word == 3'(c)) begin
                    for (int p = 0; p < PORTS; p++) begin
                        bus_rdata[LANE_W*port_lane(p, REVERSED) +: LANE_W] = st_q.cpu_en[c][LANE_W*p +: LANE_W];
                    end
                end
            end
        end
    end

    assign pin_out = st_q.dout;
    assign pin_oe  = st_q.dir;
    assign pin_alt = st_q.alt;

    assert_no_lane_no_change_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_be == 4'b0000) |=> $stable(st_q));

    assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (pending == '0) |-> (irq == '0));

    assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !cpu_win && (word == 3'd1 || word == 3'd7)) |=> $stable(st_q));
endmodule

// File: tb/gpio_edge_bank_test.sv
module gpio_edge_bank_test;
    localparam int CLK_NS = 10;
    localparam int NCPU   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_waddr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pins = '0;
    logic [31:0] rdata, rdata_rev;
    logic [31:0] pout, poe, palt, pout_r, poe_r, palt_r;
    logic [NCPU-1:0] irq, irq_r;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    gpio_edge_bank #(.NUM_CPUS(NCPU), .HAS_CPU_WIN(1'b1), .REVERSED(1'b0)) uut (
        .clk(clk), .rst(rst), .bus_waddr(bus_waddr), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .pin_in(pins), .pin_out(pout),
        .pin_oe(poe), .pin_alt(palt), .irq(irq)
    );

    gpio_edge_bank #(.NUM_CPUS(NCPU), .HAS_CPU_WIN(1'b1), .REVERSED(1'b1)) uut_rev (
        .clk(clk), .rst(rst), .bus_waddr(bus_waddr), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_rev), .pin_in(pins), .pin_out(pout_r),
        .pin_oe(poe_r), .pin_alt(palt_r), .irq(irq_r)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural model of the normal-order instance (lane-centric decode)
    bit [31:0] m_alt, m_dir, m_dout, m_pend, m_s1, m_s2, m_prev;
    bit [63:0] m_emask;
    bit [31:0] m_cpu [NCPU];

    always @(posedge clk) begin
        bit [31:0] hit, clr;
        bit [1:0]  f;
        bit [7:0]  v;
        if (rst) begin
            m_alt = 0; m_dir = 0; m_dout = 0; m_pend = 0; m_emask = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0;
            for (int c = 0; c < NCPU; c++) m_cpu[c] = 32'hFFFF_FFFF;
        end else begin
            hit = 0; clr = 0;
            for (int i = 0; i < 32; i++) begin
                f = m_emask[2*i +: 2];
                if (m_s2[i] && !m_prev[i] && f[1]) hit[i] = 1'b1;
                if (!m_s2[i] && m_prev[i] && f[0]) hit[i] = 1'b1;
            end
            if (bus_wr) begin
                for (int b = 0; b < 4; b++) begin
                    if (bus_be[b]) begin
                        v = bus_wdata[8*b +: 8];
                        case (bus_waddr)
                            4'd0: m_alt[8*b +: 8] = v;
                            4'd2: m_dir[8*b +: 8] = v;
                            4'd3: m_dout[8*b +: 8] = v;
                            4'd4: clr[8*b +: 8] = v;
                            4'd5: m_emask[16*(b/2) + 8*(b%2) +: 8] = v;
                            4'd6: m_emask[32 + 16*(b/2) + 8*(b%2) +: 8] = v;
                            4'd8: m_cpu[0][8*b +: 8] = v;
                            4'd9: m_cpu[1][8*b +: 8] = v;
                            default: ;
                        endcase
                    end
                end
            end
            m_pend = (m_pend & ~clr) | hit;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [NCPU-1:0] ei;
        if (!rst && !fin) begin
            for (int c = 0; c < NCPU; c++) ei[c] = |(m_pend & m_cpu[c]);
            chk("R2 model pin_out", pout, m_dout);
            chk("R2 model pin_oe", poe, m_dir);
            chk("R2 model pin_alt", palt, m_alt);
            chk("R10 model irq", 32'(irq), 32'(ei));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_waddr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_waddr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic rd_rev(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_waddr = a;
        #1;
        chk(tag, rdata_rev, exp);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            fin = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int w = 0; w < 8; w++) rd(4'(w), 32'h0, "R1 main word reset");
        rd(4'd8, 32'hFFFF_FFFF, "R1 cpu0 enables reset");
        rd(4'd9, 32'hFFFF_FFFF, "R1 cpu1 enables reset");
        chk("R1 irq reset", 32'(irq), 32'h0);

        // R2: direction, data, pin-select
        wr(4'd2, 4'hF, 32'h0000_FF0F);
        wr(4'd3, 4'hF, 32'hA5A5_A5A5);
        wr(4'd0, 4'hF, 32'h00F0_0000);
        chk("R2 pin_oe", poe, 32'h0000_FF0F);
        chk("R2 pin_out", pout, 32'hA5A5_A5A5);
        chk("R2 pin_alt", palt, 32'h00F0_0000);

        // R4: lane enables
        wr(4'd2, 4'b0100, 32'hFFFF_FFFF);
        chk("R4 single lane", poe, 32'h00FF_FF0F);
        wr(4'd3, 4'b0000, 32'h0000_0000);
        chk("R4 no lanes", pout, 32'hA5A5_A5A5);
        // R9: reversed lanes on the same writes
        chk("R9 reversed pin_oe", poe_r, 32'h0FFF_FF00);
        chk("R9 reversed pin_alt", palt_r, 32'h0000_F000);

        // R3: data read mixes driven and sampled values
        pins = 32'h1234_5678;
        repeat (2) @(negedge clk);
        rd(4'd3, 32'h12A5_A575, "R3 data readback");
        rd(4'd2, 32'h00FF_FF0F, "R8 dir lanes");

        // R5: edge types on port 0 pins 0..3 = fall, rise, any, off
        wr(4'd2, 4'hF, 32'h0);
        pins = 32'h0;
        settle();
        wr(4'd4, 4'hF, 32'hFFFF_FFFF);
        wr(4'd5, 4'hF, 32'h0000_0039);
        rd(4'd5, 32'h0000_0039, "R8 edge mask low word");
        pins = 32'h0000_000F;
        settle();
        rd(4'd4, 32'h0000_0006, "R5 rising edges");
        chk("R10 irq with default enables", 32'(irq), 32'h3);
        wr(4'd4, 4'hF, 32'hFFFF_FFFF);
        pins = 32'h0;
        settle();
        rd(4'd4, 32'h0000_0005, "R5 falling edges");

        // R6: write-one-to-clear
        wr(4'd4, 4'hF, 32'h0000_0001);
        rd(4'd4, 32'h0000_0004, "R6 clear one bit");
        wr(4'd4, 4'hF, 32'h0000_0000);
        rd(4'd4, 32'h0000_0004, "R6 zero write keeps");
        wr(4'd4, 4'hF, 32'h0000_0004);
        rd(4'd4, 32'h0000_0000, "R6 cleared");

        // R7: clear and new edge on the same clock edge
        pins[1] = 1'b1;
        @(negedge clk);
        wr(4'd4, 4'hF, 32'h0000_0002);
        rd(4'd4, 32'h0000_0002, "R7 set wins over clear");
        wr(4'd4, 4'hF, 32'hFFFF_FFFF);
        pins[1] = 1'b0;
        settle();
        wr(4'd4, 4'hF, 32'hFFFF_FFFF);
        rd(4'd4, 32'h0000_0000, "R6 clean before routing");

        // R10: per-CPU routing
        wr(4'd8, 4'hF, 32'h0000_0001);
        wr(4'd9, 4'hF, 32'h0000_0002);
        rd(4'd8, 32'h0000_0001, "R10 cpu0 enables");
        chk("R10 idle irq", 32'(irq), 32'h0);
        pins[0] = 1'b1;
        settle();
        chk("R10 rise on fall-only pin", 32'(irq), 32'h0);
        pins[0] = 1'b0;
        settle();
        chk("R10 cpu0 only", 32'(irq), 32'h1);
        pins[1] = 1'b1;
        settle();
        chk("R10 both cpus", 32'(irq), 32'h3);
        wr(4'd4, 4'hF, 32'h0000_0001);
        chk("R10 cpu1 only", 32'(irq), 32'h2);
        wr(4'd4, 4'hF, 32'hFFFF_FFFF);

        // R8: port 3 field in the high half of word 6
        wr(4'd6, 4'hF, 32'h0002_0000);
        pins[24] = 1'b1;
        settle();
        rd(4'd4, 32'h0100_0000, "R8 port3 pending lane");
        chk("R8 port3 not enabled for cpus", 32'(irq), 32'h0);

        // R9: reversed edge-mask halves and pending lanes
        wr(4'd4, 4'hF, 32'hFFFF_FFFF);
        rd_rev(4'd4, 32'h0, "R9 reversed pending clean");
        rd_rev(4'd5, 32'h0000_0039, "R9 reversed mask word");
        pins[9] = 1'b1;
        settle();
        rd_rev(4'd4, 32'h0002_0000, "R9 reversed port1 pin1 rising");
        rd(4'd4, 32'h0000_0000, "R8 normal port1 disabled");

        // R11: unmapped words
        wr(4'd1, 4'hF, 32'hFFFF_FFFF);
        wr(4'd7, 4'hF, 32'hFFFF_FFFF);
        wr(4'd10, 4'hF, 32'hFFFF_FFFF);
        rd(4'd1, 32'h0, "R11 word1 reads zero");
        rd(4'd7, 32'h0, "R11 word7 reads zero");
        rd(4'd10, 32'h0, "R11 missing cpu reads zero");
        rd(4'd2, 32'h0, "R11 direction untouched");
        rd(4'd8, 32'h0000_0001, "R11 cpu0 untouched");

        @(negedge clk);
        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule